// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a small programmable logic device. It sits between the OR-sum of a product-term array and an I/O pad. Two configuration bits set its behaviour. One bit chooses registered operation, where a D flip-flop captures the sum on each rising clock edge and drives the pad, or combinatorial operation, where the sum goes straight to the pad. The other bit chooses whether the pad carries the true or the inverted value. A separate product term per cell gates the pad driver.

The cell also returns a feedback signal to the array, in both polarities. In registered operation the feedback is taken from the inverted register output, so the pad acts only as an output. In combinatorial operation the feedback is the level actually present on the pad. When the driver is released, that level comes from outside, so the pad can serve as an input.

The register can be changed in four ways besides normal capture:
- a clear term shared by all cells, which acts without a clock;
- a set term shared by all cells, which acts on the next clock edge;
- a test preload that loads any chosen value;
- the power-on reset.

All of these act on the stored state, not on the pad level, so the pad level that results depends on the polarity setting.

Top module: `pld_out_macrocell`

## Requirements
- R1: While `rst_n` is low the register holds 0. It stays 0 until the synchronised release (two rising edges after `rst_n` rises). With `cfg_comb`=0, `pin_out` then equals the inverse of `cfg_pol_hi`.
- R2: With `cfg_comb`=0 (registered), the stored bit takes `sum_in` at each rising clock edge when no clear, set or preload is active. `pin_out` follows that stored bit.
- R3: With `cfg_comb`=1 (combinatorial), `pin_out` follows `sum_in` within the same cycle, with no clock edge involved.
- R4: `cfg_pol_hi`=1 makes `pin_out` equal the selected data, and `cfg_pol_hi`=0 makes it the inverse. This holds in both modes and takes effect without a clock edge.
- R5: `pin_oe` follows `oe_term` in both modes. `pin_out` keeps its driven value when `pin_oe` is 0.
- R6: With `cfg_comb`=0, `fb_true` is the inverse of the stored bit. It is not affected by `pad_in` or by `oe_term`.
- R7: With `cfg_comb`=1, `fb_true` is the pad level: `pin_out` when `pin_oe` is 1, and `pad_in` when `pin_oe` is 0.
- R8: `fb_comp` is always the inverse of `fb_true`.
- R9: While `clr_term` is 1 the stored bit is 0 at once, without waiting for a clock edge. This clear wins over `set_term` and over `pl_en`.
- R10: When `set_term` is 1 at a rising edge, and neither `clr_term` nor `pl_en` is active, the stored bit becomes 1. This happens whatever `sum_in` is.
- R11: When `pl_en` is 1 at a rising edge and `clr_term` is 0, the stored bit becomes `pl_val`. This wins over `set_term` and `sum_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Array clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| cfg_comb | input | 1 | Mode bit: 0 registered, 1 combinatorial |
| cfg_pol_hi | input | 1 | Polarity bit: 1 true, 0 inverted |
| sum_in | input | 1 | OR-sum of the cell's product terms |
| oe_term | input | 1 | Output-enable product term |
| clr_term | input | 1 | Shared clear term, asynchronous, active high |
| set_term | input | 1 | Shared set term, synchronous, active high |
| pl_en | input | 1 | Test preload strobe |
| pl_val | input | 1 | Test preload value |
| pad_in | input | 1 | Level seen on the pad when the driver is released |
| pin_out | output | 1 | Pad drive value |
| pin_oe | output | 1 | Pad driver enable |
| fb_true | output | 1 | Feedback to array, true form |
| fb_comp | output | 1 | Feedback to array, complement form |

## Verification
The assertions check on every cycle the relations that do not depend on history:
- in combinatorial mode, the pad value against the sum and the polarity;
- the feedback source in each mode;
- the clear forcing the inactive pad level in registered mode;
- the one-edge results of set and preload.

Other behaviours can only be shown by the directed scenarios:
- the ordering when clear, set and preload overlap;
- the clear taking effect between clock edges;
- the pad-input path while the driver is released;
- the reset level after release for each polarity.

// File: rtl/olmc_pkg.sv
package olmc_pkg;
  typedef enum logic {
    MODE_REG  = 1'b0,
    MODE_COMB = 1'b1
  } olmc_mode_e;

  function automatic logic apply_pol(input logic val, input logic pol_hi);
    return pol_hi ? val : ~val;
  endfunction
endpackage

// File: rtl/olmc_rst_sync.sv
module olmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic core_rst_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign core_rst_n = sync_q[LAST];
endmodule

// File: rtl/olmc_state_reg.sv
module olmc_state_reg (
  input  logic clk,
  input  logic core_rst_n,
  input  logic clr_term,
  input  logic set_term,
  input  logic pl_en,
  input  logic pl_val,
  input  logic sum_in,
  output logic q
);
  logic q_nxt;

  // Synchronous priority: preload, then set, then the sum.
  always_comb begin
    if (pl_en)         q_nxt = pl_val;
    else if (set_term) q_nxt = 1'b1;
    else               q_nxt = sum_in;
  end

  // Clear acts without a clock and wins over every synchronous source.
  always_ff @(posedge clk or negedge core_rst_n or posedge clr_term) begin
    if (!core_rst_n)   q <= 1'b0;
    else if (clr_term) q <= 1'b0;
    else               q <= q_nxt;
  end
endmodule

// File: rtl/olmc_out_path.sv
module olmc_out_path
  import olmc_pkg::*;
(
  input  olmc_mode_e mode,
  input  logic       pol_hi,
  input  logic       q,
  input  logic       sum_in,
  input  logic       oe_term,
  input  logic       pad_in,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       fb_true,
  output logic       fb_comp
);
  logic data_sel;
  logic pad_level;

  always_comb begin
    data_sel  = (mode == MODE_COMB) ? sum_in : q;
    pin_out   = apply_pol(data_sel, pol_hi);
    pin_oe    = oe_term;
    pad_level = pin_oe ? pin_out : pad_in;
    fb_true   = (mode == MODE_COMB) ? pad_level : ~q;
    fb_comp   = ~fb_true;
  end
endmodule

// File: rtl/pld_out_macrocell.sv
module pld_out_macrocell
  import olmc_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_comb,
  input  logic cfg_pol_hi,
  input  logic sum_in,
  input  logic oe_term,
  input  logic clr_term,
  input  logic set_term,
  input  logic pl_en,
  input  logic pl_val,
  input  logic pad_in,
  output logic pin_out,
  output logic pin_oe,
  output logic fb_true,
  output logic fb_comp
);
  logic       core_rst_n;
  logic       q;
  olmc_mode_e mode;

  assign mode = olmc_mode_e'(cfg_comb);

  olmc_rst_sync #(.STAGES(RST_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_rst_n (core_rst_n)
  );

  olmc_state_reg u_reg (
    .clk        (clk),
    .core_rst_n (core_rst_n),
    .clr_term   (clr_term),
    .set_term   (set_term),
    .pl_en      (pl_en),
    .pl_val     (pl_val),
    .sum_in     (sum_in),
    .q          (q)
  );

  olmc_out_path u_out (
    .mode    (mode),
    .pol_hi  (cfg_pol_hi),
    .q       (q),
    .sum_in  (sum_in),
    .oe_term (oe_term),
    .pad_in  (pad_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .fb_true (fb_true),
    .fb_comp (fb_comp)
  );
endmodule

// File: rtl/olmc_chk.sv
module olmc_chk (
  input logic clk,
  input logic rst_ok,
  input logic cfg_comb,
  input logic cfg_pol_hi,
  input logic sum_in,
  input logic clr_term,
  input logic set_term,
  input logic pl_en,
  input logic pl_val,
  input logic pad_in,
  input logic pin_out,
  input logic pin_oe,
  input logic fb_true,
  input logic fb_comp
);
  AST_COMB_PATH: assert property (@(posedge clk) disable iff (!rst_ok) cfg_comb |-> pin_out == (sum_in ^ !cfg_pol_hi)); // R3
  AST_COMB_FB: assert property (@(posedge clk) disable iff (!rst_ok) cfg_comb |-> fb_true == (pin_oe ? pin_out : pad_in)); // R7
  AST_REG_FB: assert property (@(posedge clk) disable iff (!rst_ok) !cfg_comb |-> fb_true == (pin_out ^ cfg_pol_hi)); // R6
  AST_FB_PAIR: assert property (@(posedge clk) disable iff (!rst_ok) fb_comp != fb_true); // R8
  AST_CLR_HOLD: assert property (@(posedge clk) disable iff (!rst_ok) (clr_term && !cfg_comb) |-> pin_out == !cfg_pol_hi); // R9
  AST_SET_EDGE: assert property (@(posedge clk) disable iff (!rst_ok) (set_term && !pl_en && !clr_term) |=> (clr_term || cfg_comb || pin_out == cfg_pol_hi)); // R10
  AST_PRELOAD_EDGE: assert property (@(posedge clk) disable iff (!rst_ok) (pl_en && !clr_term) |=> (clr_term || cfg_comb || pin_out == ($past(pl_val) ^ !cfg_pol_hi))); // R11
endmodule

bind pld_out_macrocell olmc_chk u_chk (
  .clk        (clk),
  .rst_ok     (core_rst_n),
  .cfg_comb   (cfg_comb),
  .cfg_pol_hi (cfg_pol_hi),
  .sum_in     (sum_in),
  .clr_term   (clr_term),
  .set_term   (set_term),
  .pl_en      (pl_en),
  .pl_val     (pl_val),
  .pad_in     (pad_in),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .fb_true    (fb_true),
  .fb_comp    (fb_comp)
);

// File: tb/sim_pld_out_macrocell.sv
`timescale 1ns/1ps
module sim_pld_out_macrocell;
  logic clk = 1'b0;
  logic rst_n, cfg_comb, cfg_pol_hi, sum_in, oe_term, clr_term;
  logic set_term, pl_en, pl_val, pad_in;
  logic pin_out, pin_oe, fb_true, fb_comp;
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  always #10 clk = ~clk;

  pld_out_macrocell u0 (
    .clk(clk), .rst_n(rst_n), .cfg_comb(cfg_comb), .cfg_pol_hi(cfg_pol_hi),
    .sum_in(sum_in), .oe_term(oe_term), .clr_term(clr_term), .set_term(set_term),
    .pl_en(pl_en), .pl_val(pl_val), .pad_in(pad_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .fb_true(fb_true), .fb_comp(fb_comp)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // Advance past one rising edge, then sample away from it.
  task automatic step();
    @(posedge clk);
    #3;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_comb = 1'b0; cfg_pol_hi = 1'b1; sum_in = 1'b1;
    oe_term = 1'b1; clr_term = 1'b0; set_term = 1'b0; pl_en = 1'b0;
    pl_val = 1'b0; pad_in = 1'b0;
    repeat (3) step();
    check(pin_out, 1'b0, "R1 reset level true polarity");
    cfg_pol_hi = 1'b0; #1;
    check(pin_out, 1'b1, "R1 reset level inverted polarity");
    @(negedge clk); rst_n = 1'b1;
    step();
    check(pin_out, 1'b1, "R1 held through first release edge");
    step(); step();
    check(pin_out, 1'b0, "R2 capture after release");
    cfg_pol_hi = 1'b1; #1;
  endtask

  task automatic t_registered();
    cfg_comb = 1'b0; cfg_pol_hi = 1'b1;
    sum_in = 1'b0; step();
    check(pin_out, 1'b0, "R2 capture 0");
    @(negedge clk); sum_in = 1'b1; #1;
    check(pin_out, 1'b0, "R2 no change before edge");
    step();
    check(pin_out, 1'b1, "R2 capture 1");
    check(fb_true, 1'b0, "R6 feedback is inverted state");
    check(fb_comp, 1'b1, "R8 complement feedback");
    cfg_pol_hi = 1'b0; #1;
    check(pin_out, 1'b0, "R4 registered inverted polarity");
    @(negedge clk); oe_term = 1'b0; pad_in = 1'b0; #1;
    check(fb_true, 1'b0, "R6 feedback ignores pad when released");
    check(pin_oe, 1'b0, "R5 enable low");
    check(pin_out, 1'b0, "R5 drive value kept when released");
    pad_in = 1'b1; #1;
    check(fb_true, 1'b0, "R6 feedback ignores pad level");
    oe_term = 1'b1; cfg_pol_hi = 1'b1; #1;
    check(pin_oe, 1'b1, "R5 enable high");
  endtask

  task automatic t_comb();
    @(negedge clk);
    cfg_comb = 1'b1; cfg_pol_hi = 1'b1; oe_term = 1'b1; sum_in = 1'b0; pad_in = 1'b1; #1;
    check(pin_out, 1'b0, "R3 comb follows 0");
    check(fb_true, 1'b0, "R7 feedback from driven pad");
    sum_in = 1'b1; #1;
    check(pin_out, 1'b1, "R3 comb follows 1 without edge");
    cfg_pol_hi = 1'b0; #1;
    check(pin_out, 1'b0, "R4 comb inverted polarity");
    check(fb_true, 1'b0, "R7 feedback is pad value not sum");
    check(fb_comp, 1'b1, "R8 complement in comb mode");
    oe_term = 1'b0; pad_in = 1'b1; #1;
    check(fb_true, 1'b1, "R7 pad input when released");
    pad_in = 1'b0; #1;
    check(fb_true, 1'b0, "R7 pad input follows outside level");
    check(fb_comp, 1'b1, "R8 complement of pad input");
    oe_term = 1'b1; cfg_pol_hi = 1'b1; cfg_comb = 1'b0; #1;
  endtask

  task automatic t_clear_set_preload();
    @(negedge clk); sum_in = 1'b1;
    step();
    check(pin_out, 1'b1, "R2 state 1 before clear");
    @(negedge clk); #2; clr_term = 1'b1; set_term = 1'b1; pl_en = 1'b1; pl_val = 1'b1; #1;
    check(pin_out, 1'b0, "R9 clear acts between edges");
    step();
    check(pin_out, 1'b0, "R9 clear wins over set and preload");
    cfg_pol_hi = 1'b0; #1;
    check(pin_out, 1'b1, "R9 cleared state shows 1 when inverted");
    @(negedge clk); clr_term = 1'b0; pl_en = 1'b0; sum_in = 1'b0; cfg_pol_hi = 1'b1;
    step();
    check(pin_out, 1'b1, "R10 set to 1 over sum 0");
    @(negedge clk); pl_en = 1'b1; pl_val = 1'b0;
    step();
    check(pin_out, 1'b0, "R11 preload 0 wins over set");
    @(negedge clk); set_term = 1'b0; pl_val = 1'b1; sum_in = 1'b0;
    step();
    check(pin_out, 1'b1, "R11 preload 1 wins over sum");
    @(negedge clk); pl_en = 1'b0;
    step();
    check(pin_out, 1'b0, "R2 sum resumes after preload");
  endtask

  initial begin
    t_reset();
    t_registered();
    t_comb();
    t_clear_set_preload();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule